// File: doc/BRIEF.md
# Page Coherence Recovery Controller

This block is the per-node engine that brings a page back under directory tracking once it has turned shared read-write. The same controller plays whichever of three roles the traffic asks for. As the initiator it asks the page's keeper to recover the page. It then waits for the keeper's reply. After that it marks the page shared read-write in its own TLB and in the page table. As the keeper it does four things:
- it locks its TLB entry;
- it sends a probe to every other node, but only when the page was shared read-only;
- it flushes its copy of the page;
- it collects acknowledgements, then unlocks the entry and answers the initiator.

As a probed sharer it locks, flushes, marks the page shared read-write, unlocks and acknowledges the keeper.

A flush walks every block index of the page and hands one eviction to the cache per accepted handshake. After the walk the controller waits until no valid miss-status entry points into the page. During the whole window it raises a fill-block signal, so that data returning for the page is not allocated into the cache. The network, the cache, the TLB and the page table sit outside. They are reached through simple valid/ready or pulse ports. The controller handles one recovery at a time.

Top module: `pcr_ctrl`

## Requirements
- R1: In idle, a pulse on `start_valid` sends one message of type REQ (code 0) to `start_keeper`. The message carries the page and the shared flag, with `msg_out_bcast` low. The controller stays busy until the reply arrives. An outgoing message holds its fields while `msg_out_ready` is low.
- R2: On an incoming REQ (or PROBE), the controller issues a TLB command LOCK (code 0) for the page when `tlb_hit` is high. When `tlb_hit` is low, it issues no TLB command at all for that whole recovery.
- R3: A keeper whose request had the shared flag set sends exactly one PROBE (code 1) with `msg_out_bcast` high before flushing. With the flag clear, it sends no probe.
- R4: The flush presents the indices 0 to BLOCKS-1 (0 to 63 by default) in ascending order on `evict_idx`, with `evict_page` equal to the page. It advances only on `evict_valid && evict_ready` and yields exactly BLOCKS evictions.
- R5: After the flush, no SET_SW command (code 1) is issued while any valid miss-status entry holds the page. From the lock until the drain ends, `fill_block` is high exactly when `fill_page` equals the page.
- R6: Once the drain ends, the controller issues SET_SW and then UNLOCK (code 2), both gated by `tlb_hit` as in R2. A probed node then sends TDONE (code 2) to the keeper that probed it.
- R7: A keeper that probed waits for NODES-1 distinct TDONE senders before it unlocks and sends RDONE (code 3) to the initiator. A keeper that did not probe sends RDONE without waiting.
- R8: A second TDONE from a node that has already acknowledged sets `ack_err`. The flag stays set until the next recovery starts.
- R9: On RDONE in its waiting state, the initiator issues one SET_SW for the page, pulses `pt_wr` and `done` once each, and returns to idle.
- R10: While busy, `start_valid` is ignored. An incoming REQ or PROBE is not accepted: `msg_in_ready` stays low for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | NID_W | Identity of this node |
| start_valid | input | 1 | Begin a recovery as initiator |
| start_page | input | PAGE_W | Page to recover |
| start_keeper | input | NID_W | Keeper taken from the page-table entry |
| start_shared | input | 1 | Page was shared read-only |
| busy | output | 1 | A recovery is in progress |
| done | output | 1 | Initiator finished (pulse) |
| msg_in_valid | input | 1 | Incoming message valid |
| msg_in_ready | output | 1 | Incoming message accepted |
| msg_in_type | input | 2 | REQ=0, PROBE=1, TDONE=2, RDONE=3 |
| msg_in_src | input | NID_W | Sender of incoming message |
| msg_in_page | input | PAGE_W | Page of incoming message |
| msg_in_shared | input | 1 | Shared flag of incoming request |
| msg_out_valid | output | 1 | Outgoing message valid |
| msg_out_ready | input | 1 | Network accepts outgoing message |
| msg_out_type | output | 2 | Outgoing message type |
| msg_out_src | output | NID_W | This node's identity |
| msg_out_dst | output | NID_W | Destination (ignored when broadcast) |
| msg_out_bcast | output | 1 | Send to all other nodes |
| msg_out_page | output | PAGE_W | Page of outgoing message |
| msg_out_shared | output | 1 | Shared flag of outgoing request |
| tlb_page | output | PAGE_W | Page the TLB looks up and writes |
| tlb_hit | input | 1 | TLB holds an entry for `tlb_page` |
| tlb_cmd_valid | output | 1 | TLB command pulse |
| tlb_cmd_op | output | 2 | LOCK=0, SET_SW=1, UNLOCK=2 |
| pt_wr | output | 1 | Write page as shared read-write in page table (pulse) |
| evict_valid | output | 1 | Eviction request valid |
| evict_ready | input | 1 | Cache accepts eviction |
| evict_page | output | PAGE_W | Page of eviction |
| evict_idx | output | IDX_W | Block index within page |
| mshr_valid | input | MSHR_N | Valid bits of miss-status entries |
| mshr_page | input | MSHR_N*PAGE_W | Page of each miss-status entry |
| fill_page | input | PAGE_W | Page of returning fill data |
| fill_block | output | 1 | Do not allocate this fill |
| ack_err | output | 1 | Duplicate acknowledgement seen |

## Verification
The bench runs one node through each role: initiator, keeper with a private page with and without a TLB entry, keeper with a shared page, and probed sharer. It throttles the eviction and message handshakes while doing so. It watches every eviction index for gaps and repeats; a flush sequencer that skipped a stalled index or stopped early would show both. It keeps a matching miss outstanding past the end of the flush. A design that ignored the miss-status entries would issue SET_SW too early, and one that compared pages loosely would block the wrong fill. It withholds the last acknowledgement and repeats one. A keeper that counted messages rather than distinct senders would answer early, and one that lost the duplicate would leave `ack_err` low.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    MSG_REQ   = 2'd0,
    MSG_PROBE = 2'd1,
    MSG_TDONE = 2'd2,
    MSG_RDONE = 2'd3
  } msg_e;

  typedef enum logic [1:0] {
    TLB_LOCK   = 2'd0,
    TLB_SET_SW = 2'd1,
    TLB_UNLOCK = 2'd2
  } tlb_op_e;

  typedef enum logic [1:0] {
    ROLE_INIT   = 2'd0,
    ROLE_KEEPER = 2'd1,
    ROLE_TARGET = 2'd2
  } role_e;
endpackage

// File: rtl/pcr_flush_seq.sv
module pcr_flush_seq #(
  parameter int BLOCKS = 64,
  localparam int IDX_W = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             evict_ready,
  output logic             evict_valid,
  output logic [IDX_W-1:0] evict_idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      evict_valid <= 1'b0;
      evict_idx   <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        evict_valid <= 1'b1;
        evict_idx   <= '0;
      end else if (evict_valid && evict_ready) begin
        if (evict_idx == LAST) begin
          evict_valid <= 1'b0;
          done        <= 1'b1;
        end else begin
          evict_idx <= evict_idx + IDX_W'(1);
        end
      end
    end
  end

  // R4: a stalled eviction keeps its index
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && !evict_ready && !start) |=> (evict_valid && $stable(evict_idx)));
  // R4: an accepted eviction moves to the next index
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && evict_ready && !start && evict_idx != LAST)
      |=> (evict_idx == $past(evict_idx) + IDX_W'(1)));
  // R4: the walk ends right after the last index is accepted
  a_r4_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (evict_valid && evict_ready && !start && evict_idx == LAST) |=> (done && !evict_valid));
endmodule

// File: rtl/pcr_mshr_match.sv
module pcr_mshr_match #(
  parameter int MSHR_N = 4,
  parameter int PAGE_W = 20
) (
  input  logic [MSHR_N-1:0]        mshr_valid,
  input  logic [MSHR_N*PAGE_W-1:0] mshr_page,
  input  logic [PAGE_W-1:0]        page,
  output logic                     hit
);
  logic [MSHR_N-1:0] match_vec;

  for (genvar g = 0; g < MSHR_N; g++) begin : g_entry
    assign match_vec[g] = mshr_valid[g] && (mshr_page[g*PAGE_W +: PAGE_W] == page);
  end

  assign hit = |match_vec;
endmodule

// File: rtl/pcr_ack_tracker.sv
module pcr_ack_tracker #(
  parameter int NODES = 8,
  localparam int NID_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ack_valid,
  input  logic [NID_W-1:0] ack_src,
  output logic             all_acked,
  output logic             dup_err
);
  localparam logic [CNT_W-1:0] NEED = CNT_W'(NODES - 1);

  logic [NODES-1:0] seen;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen    <= '0;
      cnt     <= '0;
      dup_err <= 1'b0;
    end else if (ack_valid) begin
      if (seen[ack_src] || cnt == NEED) begin
        dup_err <= 1'b1;
      end else begin
        seen[ack_src] <= 1'b1;
        cnt           <= cnt + CNT_W'(1);
      end
    end
  end

  assign all_acked = (cnt == NEED);

  // R7: never more acknowledgements than other nodes
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= NEED);
  // R8: a repeated sender raises the error flag
  a_r8_dup_flags: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !clr && seen[ack_src]) |=> dup_err);
  // R7: the count equals the number of distinct senders recorded
  a_r7_count_matches: assert property (@(posedge clk) disable iff (rst)
    cnt == CNT_W'($countones(seen)));
endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
  import pcr_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int PAGE_W = 20,
  parameter int BLOCKS = 64,
  parameter int MSHR_N = 4,
  localparam int NID_W = $clog2(NODES),
  localparam int IDX_W = $clog2(BLOCKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NID_W-1:0]         node_id,
  input  logic                     start_valid,
  input  logic [PAGE_W-1:0]        start_page,
  input  logic [NID_W-1:0]         start_keeper,
  input  logic                     start_shared,
  output logic                     busy,
  output logic                     done,
  input  logic                     msg_in_valid,
  output logic                     msg_in_ready,
  input  logic [1:0]               msg_in_type,
  input  logic [NID_W-1:0]         msg_in_src,
  input  logic [PAGE_W-1:0]        msg_in_page,
  input  logic                     msg_in_shared,
  output logic                     msg_out_valid,
  input  logic                     msg_out_ready,
  output logic [1:0]               msg_out_type,
  output logic [NID_W-1:0]         msg_out_src,
  output logic [NID_W-1:0]         msg_out_dst,
  output logic                     msg_out_bcast,
  output logic [PAGE_W-1:0]        msg_out_page,
  output logic                     msg_out_shared,
  output logic [PAGE_W-1:0]        tlb_page,
  input  logic                     tlb_hit,
  output logic                     tlb_cmd_valid,
  output logic [1:0]               tlb_cmd_op,
  output logic                     pt_wr,
  output logic                     evict_valid,
  input  logic                     evict_ready,
  output logic [PAGE_W-1:0]        evict_page,
  output logic [IDX_W-1:0]         evict_idx,
  input  logic [MSHR_N-1:0]        mshr_valid,
  input  logic [MSHR_N*PAGE_W-1:0] mshr_page,
  input  logic [PAGE_W-1:0]        fill_page,
  output logic                     fill_block,
  output logic                     ack_err
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_I_REQ, ST_I_WAIT, ST_I_FIN, ST_LOCK, ST_PROBE, ST_FLUSH,
    ST_DRAIN, ST_SETSW, ST_K_WAIT, ST_UNLOCK, ST_T_ACK, ST_K_DONE
  } state_e;

  state_e            state;
  role_e             role;
  logic [PAGE_W-1:0] cur_page;
  logic [NID_W-1:0]  peer;
  logic              shared_q;
  logic              hit_q;
  logic              probe_sent;
  logic              flush_start;
  logic              flush_done;
  logic              mshr_hit;
  logic              ack_all;
  logic              ack_fire;
  logic              ack_clr;
  logic              ack_open;
  logic              in_fire;
  logic              out_fire;
  logic              window;

  assign in_fire  = msg_in_valid && msg_in_ready;
  assign out_fire = msg_out_valid && msg_out_ready;
  assign ack_open = (role == ROLE_KEEPER) && probe_sent && (state != ST_IDLE);

  always_comb begin
    msg_in_ready = 1'b0;
    if (state == ST_IDLE)
      msg_in_ready = !start_valid;
    else if (state == ST_I_WAIT && msg_in_type == MSG_RDONE)
      msg_in_ready = 1'b1;
    else if (ack_open && msg_in_type == MSG_TDONE)
      msg_in_ready = 1'b1;
  end

  assign ack_fire = in_fire && ack_open && (msg_in_type == MSG_TDONE);
  assign ack_clr  = (state == ST_IDLE) && (start_valid ||
                    (in_fire && (msg_in_type == MSG_REQ || msg_in_type == MSG_PROBE)));

  assign busy        = (state != ST_IDLE);
  assign tlb_page    = cur_page;
  assign evict_page  = cur_page;
  assign msg_out_src = node_id;
  assign window      = (state == ST_LOCK) || (state == ST_PROBE) ||
                       (state == ST_FLUSH) || (state == ST_DRAIN);
  assign fill_block  = window && (fill_page == cur_page);

  pcr_flush_seq #(.BLOCKS(BLOCKS)) u_flush (
    .clk(clk), .rst(rst), .start(flush_start), .evict_ready(evict_ready),
    .evict_valid(evict_valid), .evict_idx(evict_idx), .done(flush_done)
  );

  pcr_mshr_match #(.MSHR_N(MSHR_N), .PAGE_W(PAGE_W)) u_match (
    .mshr_valid(mshr_valid), .mshr_page(mshr_page), .page(cur_page), .hit(mshr_hit)
  );

  pcr_ack_tracker #(.NODES(NODES)) u_acks (
    .clk(clk), .rst(rst), .clr(ack_clr), .ack_valid(ack_fire), .ack_src(msg_in_src),
    .all_acked(ack_all), .dup_err(ack_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      role           <= ROLE_INIT;
      cur_page       <= '0;
      peer           <= '0;
      shared_q       <= 1'b0;
      hit_q          <= 1'b0;
      probe_sent     <= 1'b0;
      flush_start    <= 1'b0;
      tlb_cmd_valid  <= 1'b0;
      tlb_cmd_op     <= TLB_LOCK;
      pt_wr          <= 1'b0;
      done           <= 1'b0;
      msg_out_valid  <= 1'b0;
      msg_out_type   <= MSG_REQ;
      msg_out_dst    <= '0;
      msg_out_bcast  <= 1'b0;
      msg_out_page   <= '0;
      msg_out_shared <= 1'b0;
    end else begin
      tlb_cmd_valid <= 1'b0;
      pt_wr         <= 1'b0;
      done          <= 1'b0;
      flush_start   <= 1'b0;
      if (out_fire) msg_out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_valid) begin
            cur_page <= start_page;
            peer     <= start_keeper;
            shared_q <= start_shared;
            role     <= ROLE_INIT;
            state    <= ST_I_REQ;
          end else if (in_fire && msg_in_type == MSG_REQ) begin
            cur_page   <= msg_in_page;
            peer       <= msg_in_src;
            shared_q   <= msg_in_shared;
            role       <= ROLE_KEEPER;
            probe_sent <= 1'b0;
            state      <= ST_LOCK;
          end else if (in_fire && msg_in_type == MSG_PROBE) begin
            cur_page   <= msg_in_page;
            peer       <= msg_in_src;
            shared_q   <= 1'b0;
            role       <= ROLE_TARGET;
            probe_sent <= 1'b0;
            state      <= ST_LOCK;
          end
        end
        ST_I_REQ: begin
          if (!msg_out_valid) begin
            msg_out_valid  <= 1'b1;
            msg_out_type   <= MSG_REQ;
            msg_out_dst    <= peer;
            msg_out_bcast  <= 1'b0;
            msg_out_page   <= cur_page;
            msg_out_shared <= shared_q;
          end else if (msg_out_ready) begin
            state <= ST_I_WAIT;
          end
        end
        ST_I_WAIT: begin
          if (in_fire && msg_in_type == MSG_RDONE) state <= ST_I_FIN;
        end
        ST_I_FIN: begin
          tlb_cmd_valid <= 1'b1;
          tlb_cmd_op    <= TLB_SET_SW;
          pt_wr         <= 1'b1;
          done          <= 1'b1;
          state         <= ST_IDLE;
        end
        ST_LOCK: begin
          hit_q <= tlb_hit;
          if (tlb_hit) begin
            tlb_cmd_valid <= 1'b1;
            tlb_cmd_op    <= TLB_LOCK;
          end
          if (role == ROLE_KEEPER && shared_q) begin
            state <= ST_PROBE;
          end else begin
            flush_start <= 1'b1;
            state       <= ST_FLUSH;
          end
        end
        ST_PROBE: begin
          if (!msg_out_valid) begin
            msg_out_valid  <= 1'b1;
            msg_out_type   <= MSG_PROBE;
            msg_out_dst    <= '0;
            msg_out_bcast  <= 1'b1;
            msg_out_page   <= cur_page;
            msg_out_shared <= 1'b1;
          end else if (msg_out_ready) begin
            probe_sent  <= 1'b1;
            flush_start <= 1'b1;
            state       <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (flush_done) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!mshr_hit) state <= ST_SETSW;
        end
        ST_SETSW: begin
          if (hit_q) begin
            tlb_cmd_valid <= 1'b1;
            tlb_cmd_op    <= TLB_SET_SW;
          end
          state <= (role == ROLE_KEEPER && shared_q) ? ST_K_WAIT : ST_UNLOCK;
        end
        ST_K_WAIT: begin
          if (ack_all) state <= ST_UNLOCK;
        end
        ST_UNLOCK: begin
          if (hit_q) begin
            tlb_cmd_valid <= 1'b1;
            tlb_cmd_op    <= TLB_UNLOCK;
          end
          state <= (role == ROLE_KEEPER) ? ST_K_DONE : ST_T_ACK;
        end
        ST_T_ACK, ST_K_DONE: begin
          if (!msg_out_valid) begin
            msg_out_valid  <= 1'b1;
            msg_out_type   <= (state == ST_T_ACK) ? MSG_TDONE : MSG_RDONE;
            msg_out_dst    <= peer;
            msg_out_bcast  <= 1'b0;
            msg_out_page   <= cur_page;
            msg_out_shared <= 1'b0;
          end else if (msg_out_ready) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a waiting outgoing message keeps its fields
  a_r1_msg_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && !msg_out_ready) |=>
      (msg_out_valid && $stable(msg_out_type) && $stable(msg_out_dst) && $stable(msg_out_page)));
  // R5: a matching outstanding miss keeps the drain waiting
  a_r5_drain_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN && mshr_hit) |=> (state == ST_DRAIN && !tlb_cmd_valid));
  // R7: a keeper that probed answers only after all acknowledgements
  a_r7_done_gated: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && msg_out_type == MSG_RDONE && role == ROLE_KEEPER && shared_q) |-> ack_all);
  // R10: no request or probe is taken while busy
  a_r10_no_new_work: assert property (@(posedge clk) disable iff (rst)
    (busy && msg_in_valid && (msg_in_type == MSG_REQ || msg_in_type == MSG_PROBE)) |-> !msg_in_ready);
  // R2: without a TLB entry no TLB command is issued by keeper or sharer
  a_r2_no_cmd_on_miss: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH && !hit_q) |-> !tlb_cmd_valid);
endmodule

// File: tb/pcr_ctrl_bench.sv
module pcr_ctrl_bench;
  localparam int NODES = 8, PAGE_W = 20, BLOCKS = 64, MSHR_N = 4;
  localparam int NID_W = 3, IDX_W = 6;

  logic clk = 0, rst = 1;
  logic [NID_W-1:0] node_id = 3'd2;
  logic start_valid = 0, start_shared = 0;
  logic [PAGE_W-1:0] start_page = '0;
  logic [NID_W-1:0] start_keeper = '0;
  logic busy, done;
  logic msg_in_valid = 0, msg_in_ready, msg_in_shared = 0;
  logic [1:0] msg_in_type = 0;
  logic [NID_W-1:0] msg_in_src = 0;
  logic [PAGE_W-1:0] msg_in_page = 0;
  logic msg_out_valid, msg_out_ready = 1, msg_out_bcast, msg_out_shared;
  logic [1:0] msg_out_type;
  logic [NID_W-1:0] msg_out_src, msg_out_dst;
  logic [PAGE_W-1:0] msg_out_page, tlb_page, evict_page;
  logic tlb_hit = 1, tlb_cmd_valid, pt_wr, evict_valid, evict_ready = 1;
  logic [1:0] tlb_cmd_op;
  logic [IDX_W-1:0] evict_idx;
  logic [MSHR_N-1:0] mshr_valid = '0;
  logic [MSHR_N*PAGE_W-1:0] mshr_page = '0;
  logic [PAGE_W-1:0] fill_page = '0;
  logic fill_block, ack_err;

  pcr_ctrl #(.NODES(NODES), .PAGE_W(PAGE_W), .BLOCKS(BLOCKS), .MSHR_N(MSHR_N)) u_pcr_ctrl (
    .clk(clk), .rst(rst), .node_id(node_id), .start_valid(start_valid),
    .start_page(start_page), .start_keeper(start_keeper), .start_shared(start_shared),
    .busy(busy), .done(done), .msg_in_valid(msg_in_valid), .msg_in_ready(msg_in_ready),
    .msg_in_type(msg_in_type), .msg_in_src(msg_in_src), .msg_in_page(msg_in_page),
    .msg_in_shared(msg_in_shared), .msg_out_valid(msg_out_valid), .msg_out_ready(msg_out_ready),
    .msg_out_type(msg_out_type), .msg_out_src(msg_out_src), .msg_out_dst(msg_out_dst),
    .msg_out_bcast(msg_out_bcast), .msg_out_page(msg_out_page), .msg_out_shared(msg_out_shared),
    .tlb_page(tlb_page), .tlb_hit(tlb_hit), .tlb_cmd_valid(tlb_cmd_valid), .tlb_cmd_op(tlb_cmd_op),
    .pt_wr(pt_wr), .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_page(evict_page),
    .evict_idx(evict_idx), .mshr_valid(mshr_valid), .mshr_page(mshr_page), .fill_page(fill_page),
    .fill_block(fill_block), .ack_err(ack_err)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int ev_cnt = 0, ev_bad = 0, pt_cnt = 0, done_cnt = 0, tlb_bad = 0;
  int tlb_ops[$];
  int m_type[$], m_dst[$], m_bc[$], m_page[$];
  logic [PAGE_W-1:0] exp_page = '0;

  // Handshake throttling on the cache and network sides
  always @(posedge clk) begin
    #1;
    cyc++;
    evict_ready   = (cyc % 3) != 0;
    msg_out_ready = (cyc % 4) != 1;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Observe handshakes and pulses between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (evict_valid && evict_ready) begin
        if (int'(evict_idx) != ev_cnt || evict_page != exp_page) ev_bad++;
        ev_cnt++;
      end
      if (tlb_cmd_valid) begin
        tlb_ops.push_back(int'(tlb_cmd_op));
        if (tlb_page != exp_page) tlb_bad++;
      end
      if (msg_out_valid && msg_out_ready) begin
        m_type.push_back(int'(msg_out_type));
        m_dst.push_back(int'(msg_out_dst));
        m_bc.push_back(int'(msg_out_bcast));
        m_page.push_back(int'(msg_out_page));
      end
      if (pt_wr) pt_cnt++;
      if (done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    ev_cnt = 0; ev_bad = 0; pt_cnt = 0; done_cnt = 0; tlb_bad = 0;
    tlb_ops.delete(); m_type.delete(); m_dst.delete(); m_bc.delete(); m_page.delete();
  endtask

  task automatic send_msg(input int t, input int src, input logic [PAGE_W-1:0] pg, input bit sh);
    bit r;
    @(posedge clk); #1;
    msg_in_valid = 1; msg_in_type = 2'(t); msg_in_src = 3'(src);
    msg_in_page = pg; msg_in_shared = sh;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); r = msg_in_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    msg_in_valid = 0;
  endtask

  task automatic wait_msgs(input int n);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (m_type.size() >= n) break;
    end
  endtask

  task automatic wait_evicts(input int n);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (ev_cnt >= n) break;
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_three_ops(input string tag);
    check(tlb_ops.size() == 3, tag, tlb_ops.size(), 3);
    if (tlb_ops.size() == 3) begin
      check(tlb_ops[0] == 0 && tlb_ops[1] == 1 && tlb_ops[2] == 2, tag,
            tlb_ops[0] * 100 + tlb_ops[1] * 10 + tlb_ops[2], 12);
    end
    check(tlb_bad == 0, tag, tlb_bad, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(!busy && !msg_out_valid && !evict_valid && !tlb_cmd_valid && !ack_err,
          "R10 reset idle", int'(busy), 0);

    // Initiator role, R1 R9 R10
    clear_logs(); exp_page = 20'h12345;
    @(posedge clk); #1;
    start_valid = 1; start_page = exp_page; start_keeper = 3'd5; start_shared = 1;
    @(posedge clk); #1; start_valid = 0;
    wait_msgs(1);
    check(m_type.size() == 1 && m_type[0] == 0, "R1 request type", m_type.size() > 0 ? m_type[0] : -1, 0);
    check(m_dst.size() == 1 && m_dst[0] == 5 && m_bc[0] == 0, "R1 request dest", m_dst.size() > 0 ? m_dst[0] : -1, 5);
    check(m_page.size() == 1 && m_page[0] == int'(exp_page), "R1 request page", m_page.size() > 0 ? m_page[0] : -1, int'(exp_page));
    check(busy, "R1 busy while waiting", int'(busy), 1);
    @(posedge clk); #1;
    start_valid = 1; start_page = 20'h00777; start_keeper = 3'd1;
    @(posedge clk); #1; start_valid = 0;
    msg_in_valid = 1; msg_in_type = 2'd0; msg_in_src = 3'd6; msg_in_page = 20'h00abc;
    begin
      int seen_ready = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); if (msg_in_ready) seen_ready++;
      end
      check(seen_ready == 0, "R10 request refused while busy", seen_ready, 0);
    end
    @(posedge clk); #1; msg_in_valid = 0;
    idle_cycles(10);
    check(m_type.size() == 1, "R10 second start ignored", m_type.size(), 1);
    send_msg(3, 5, exp_page, 0);
    idle_cycles(6);
    check(done_cnt == 1 && pt_cnt == 1, "R9 done and page table", done_cnt * 10 + pt_cnt, 11);
    check(tlb_ops.size() == 1 && tlb_ops[0] == 1, "R9 initiator set shared-write",
          tlb_ops.size() > 0 ? tlb_ops[0] : -1, 1);
    check(!busy, "R9 back to idle", int'(busy), 0);

    // Keeper, private page, TLB hit, matching miss outstanding: R2 R3 R4 R5 R6 R7
    clear_logs(); exp_page = 20'h0a0b0; tlb_hit = 1;
    mshr_valid = 4'b0011;
    mshr_page = {20'd0, 20'd0, 20'h0ffff, exp_page};
    send_msg(0, 1, exp_page, 0);
    wait_evicts(BLOCKS);
    idle_cycles(20);
    check(ev_cnt == BLOCKS && ev_bad == 0, "R4 ordered flush", ev_cnt * 1000 + ev_bad, BLOCKS * 1000);
    check(tlb_ops.size() == 1 && tlb_ops[0] == 0, "R2 lock only, R5 no early set", tlb_ops.size(), 1);
    check(m_type.size() == 0, "R3 no probe for private page", m_type.size(), 0);
    fill_page = exp_page; @(negedge clk);
    check(fill_block, "R5 fill of page blocked", int'(fill_block), 1);
    fill_page = 20'h0ffff; @(negedge clk);
    check(!fill_block, "R5 other fill allowed", int'(fill_block), 0);
    mshr_valid = 4'b0010;
    wait_msgs(1);
    idle_cycles(4);
    check_three_ops("R6 keeper lock/set/unlock");
    check(m_type.size() == 1 && m_type[0] == 3 && m_dst[0] == 1, "R7 private done to initiator",
          m_type.size() > 0 ? m_type[0] * 10 + m_dst[0] : -1, 31);
    check(ev_cnt == BLOCKS, "R4 no extra evictions", ev_cnt, BLOCKS);
    mshr_valid = '0;

    // Keeper without TLB entry: R2
    clear_logs(); exp_page = 20'h33333; tlb_hit = 0;
    send_msg(0, 3, exp_page, 0);
    wait_msgs(1);
    idle_cycles(4);
    check(tlb_ops.size() == 0, "R2 no TLB command without entry", tlb_ops.size(), 0);
    check(ev_cnt == BLOCKS && ev_bad == 0, "R4 flush without entry", ev_cnt, BLOCKS);
    check(m_type.size() == 1 && m_type[0] == 3 && m_dst[0] == 3, "R7 done dest 3",
          m_dst.size() > 0 ? m_dst[0] : -1, 3);

    // Keeper, shared read-only page: R3 R7 R8
    clear_logs(); exp_page = 20'h44444; tlb_hit = 1;
    send_msg(0, 6, exp_page, 1);
    wait_msgs(1);
    check(m_type.size() == 1 && m_type[0] == 1 && m_bc[0] == 1, "R3 broadcast probe",
          m_type.size() > 0 ? m_type[0] * 10 + m_bc[0] : -1, 11);
    wait_evicts(BLOCKS);
    send_msg(2, 0, exp_page, 0);
    send_msg(2, 1, exp_page, 0);
    send_msg(2, 3, exp_page, 0);
    send_msg(2, 4, exp_page, 0);
    send_msg(2, 5, exp_page, 0);
    send_msg(2, 6, exp_page, 0);
    idle_cycles(30);
    check(m_type.size() == 1, "R7 waits for last acknowledgement", m_type.size(), 1);
    check(!ack_err, "R8 no error on distinct acks", int'(ack_err), 0);
    send_msg(2, 4, exp_page, 0);
    idle_cycles(3);
    check(ack_err, "R8 duplicate flagged", int'(ack_err), 1);
    check(m_type.size() == 1, "R7 duplicate does not complete", m_type.size(), 1);
    send_msg(2, 7, exp_page, 0);
    wait_msgs(2);
    idle_cycles(4);
    check(m_type.size() == 2 && m_type[1] == 3 && m_dst[1] == 6, "R7 shared done to initiator",
          m_type.size() > 1 ? m_type[1] * 10 + m_dst[1] : -1, 36);
    check_three_ops("R6 shared keeper ops");
    check(ack_err, "R8 error held after finish", int'(ack_err), 1);

    // Probed sharer: R6 R8
    clear_logs(); exp_page = 20'h55555;
    send_msg(1, 4, exp_page, 1);
    idle_cycles(2);
    check(!ack_err, "R8 error cleared by new recovery", int'(ack_err), 0);
    wait_msgs(1);
    idle_cycles(4);
    check(m_type.size() == 1 && m_type[0] == 2 && m_dst[0] == 4 && m_bc[0] == 0, "R6 target done to keeper",
          m_type.size() > 0 ? m_type[0] * 10 + m_dst[0] : -1, 24);
    check(ev_cnt == BLOCKS && ev_bad == 0, "R4 sharer flush", ev_cnt, BLOCKS);
    check_three_ops("R6 sharer ops");
    check(!busy, "R10 idle at end", int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule